// File: doc/BRIEF.md
# System Clock Source Switch with Failover

This block decides which of three clock sources feeds the system clock: an on-chip RC oscillator, an off-chip crystal (or bypassed external clock), and the main PLL. The PLL itself can be fed from either of the first two. Each source is represented in one reference clock domain by a ready flag and a per-cycle enable pulse. The block forwards the enable pulses of the active source as a single gated enable stream.

Software writes the desired source into a request field. The block reports the source that is actually driving the system clock in a separate status field. A request for a source that is not ready stays pending, and the block carries out the switch on its own once that source reports ready. Every handoff inserts one idle cycle, so pulses from two sources never meet on the output.

A supervisor watches a failure-detect input while supervision is enabled. On a failure it raises a sticky failure flag. That flag drives a non-maskable interrupt line and a command that turns the crystal off. If the active source depends on the crystal, the supervisor forces the system clock back to the RC source at once. Requests that depend on the crystal then resolve to the RC source. This holds until the flag is cleared and the crystal reports ready again.

Top module: `sysclk_switch`

## Requirements
- R1: After reset `actSrc` is 00, `failFlag`, `nmi` and `extOff` are 0, and `clkEn` follows `srcTick[0]`.
- R2: Source codes are 00 = RC, 01 = crystal, 10 = PLL. This holds for both `reqSrc` and `actSrc`. A request of 11 is handled as 00. `actSrc` never shows 11.
- R3: A switch to a requested source starts only in a cycle where that source's ready bit is 1. Bit index equals the source code. A request that is waiting starts its switch in the first cycle its ready bit is 1.
- R4: A switch started at a clock edge makes the following cycle a gap cycle, with `clkEn` = 0. `actSrc` shows the new source from the edge after that. In all other cycles `clkEn` equals `srcTick[actSrc]`.
- R5: `actSrc` changes only at the edge that ends a gap cycle, so enable pulses of the old and new source never overlap.
- R6: When `guardEn` and `extFail` are both 1 at an edge, `failFlag` is 1 after that edge. `nmi` and `extOff` equal `failFlag`. When `guardEn` is 0, `extFail` has no effect.
- R7: A failure while the active source depends on the crystal starts a switch to the RC source at that edge, even if the RC ready bit is 0. A source depends on the crystal if it is code 01, or code 10 with `pllFromExt` = 1. If the failure lands in a gap that would hand over to a crystal-dependent source, the handoff goes to the RC source instead.
- R8: `failFlag` stays 1 until an edge where `failClr` is 1 and no new failure occurs. A new failure wins over a clear in the same cycle.
- R9: After a failure, a request for a crystal-dependent source is handled as an RC request. This lockout ends at the first edge where `failFlag` is already 0 and the crystal ready bit (bit 1) is 1.
- R10: A PLL source counts as crystal-dependent only while `pllFromExt` is 1. With `pllFromExt` = 0, a failure sets the flag but does not move an active PLL source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqSrc | input | 2 | Requested source code |
| srcRdy | input | 3 | Ready flags; bit n belongs to source code n |
| srcTick | input | 3 | Enable pulses of each source |
| guardEn | input | 1 | Enables crystal supervision |
| pllFromExt | input | 1 | 1: PLL is fed from the crystal; 0: from the RC source |
| extFail | input | 1 | Crystal failure detected |
| failClr | input | 1 | Clears the failure flag |
| actSrc | output | 2 | Source currently driving the system clock |
| clkEn | output | 1 | Enable stream of the active source |
| extOff | output | 1 | Command to stop the crystal oscillator |
| failFlag | output | 1 | Sticky failure flag |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before each rising edge. They also assume that `extFail` may arrive at any time, including during a gap cycle. The bench changes inputs only at falling edges and draws tick and ready patterns at random. Failure and clear pulses are kept sparse, so that gap cycles, lockout periods and simultaneous set/clear all occur inside the compared window. `pllFromExt` changes only occasionally, as a configuration bit would, but the bench makes no assumption about when it changes.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  localparam int NUM_SRC = 3;
  localparam int SEL_W   = $clog2(NUM_SRC);

  localparam logic [SEL_W-1:0] SRC_INT = 2'b00;
  localparam logic [SEL_W-1:0] SRC_EXT = 2'b01;
  localparam logic [SEL_W-1:0] SRC_PLL = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic             launch;    // start a handoff (next cycle is a gap)
    logic [SEL_W-1:0] dest;      // source to hand over to
    logic             redirect;  // divert a pending handoff to the RC source
  } swStrobe_t;

  function automatic logic usesExt(input logic [SEL_W-1:0] s, input logic pllExt);
    return (s == SRC_EXT) || ((s == SRC_PLL) && pllExt);
  endfunction
endpackage

// File: rtl/sysclk_ctrl.sv
`timescale 1ns/1ps
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   reqSrc,
  input  logic [NUM_SRC-1:0] srcRdy,
  input  logic               guardEn,
  input  logic               pllFromExt,
  input  logic               extFail,
  input  logic               failClr,
  input  logic [SEL_W-1:0]   actSrc,
  input  logic [SEL_W-1:0]   pendSrc,
  input  logic               gapQ,
  output swStrobe_t          strobe,
  output logic               failQ
);
  logic             blockQ;
  logic             failEvt;
  logic             forceC;
  logic             forceNow;
  logic [SEL_W-1:0] reqDec;
  logic [SEL_W-1:0] tgt;
  logic             tgtRdy;

  always_comb begin
    failEvt  = guardEn & extFail;
    forceC   = failEvt | blockQ;
    reqDec   = (reqSrc == 2'b11) ? SRC_INT : reqSrc;
    tgt      = (forceC && usesExt(reqDec, pllFromExt)) ? SRC_INT : reqDec;
    forceNow = forceC && usesExt(actSrc, pllFromExt);
    tgtRdy   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (tgt == SEL_W'(i)) tgtRdy = srcRdy[i];
    end
  end

  always_comb begin
    strobe.redirect = failEvt && usesExt(pendSrc, pllFromExt);
    strobe.launch   = !gapQ && (forceNow || ((tgt != actSrc) && tgtRdy));
    strobe.dest     = forceNow ? SRC_INT : tgt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failQ  <= 1'b0;
      blockQ <= 1'b0;
    end else begin
      if (failEvt)      failQ <= 1'b1;
      else if (failClr) failQ <= 1'b0;

      if (failEvt)                           blockQ <= 1'b1;
      else if (!failQ && srcRdy[SRC_EXT])    blockQ <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_dp.sv
`timescale 1ns/1ps
module sysclk_dp
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  swStrobe_t          strobe,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [SEL_W-1:0]   actSrc,
  output logic [SEL_W-1:0]   pendSrc,
  output logic               gapQ,
  output logic               clkEn
);
  logic [NUM_SRC-1:0] gated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSrc  <= SRC_INT;
      pendSrc <= SRC_INT;
      gapQ    <= 1'b0;
    end else if (gapQ) begin
      actSrc  <= strobe.redirect ? SRC_INT : pendSrc;
      gapQ    <= 1'b0;
    end else if (strobe.launch) begin
      pendSrc <= strobe.dest;
      gapQ    <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    assign gated[i] = srcTick[i] & ~gapQ & (actSrc == SEL_W'(i));
  end

  assign clkEn = |gated;
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sysclk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   reqSrc,
  input  logic [2:0]   srcRdy,
  input  logic [2:0]   srcTick,
  input  logic         guardEn,
  input  logic         pllFromExt,
  input  logic         extFail,
  input  logic         failClr,
  output logic [1:0]   actSrc,
  output logic         clkEn,
  output logic         extOff,
  output logic         failFlag,
  output logic         nmi
);
  swStrobe_t  strobe;
  logic [1:0] pendSrc;
  logic       swGap;
  logic       failQ;

  sysclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqSrc(reqSrc), .srcRdy(srcRdy),
    .guardEn(guardEn), .pllFromExt(pllFromExt), .extFail(extFail),
    .failClr(failClr), .actSrc(actSrc), .pendSrc(pendSrc), .gapQ(swGap),
    .strobe(strobe), .failQ(failQ)
  );

  sysclk_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcTick(srcTick),
    .actSrc(actSrc), .pendSrc(pendSrc), .gapQ(swGap), .clkEn(clkEn)
  );

  assign failFlag = failQ;
  assign nmi      = failQ;
  assign extOff   = failQ;
endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] actSrc,
  input logic       clkEn,
  input logic [2:0] srcTick,
  input logic       guardEn,
  input logic       extFail,
  input logic       failClr,
  input logic       failFlag,
  input logic       nmi,
  input logic       gapQ
);
  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    actSrc != 2'b11);

  assert_stream_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> (!gapQ && ((actSrc == 2'b00 && srcTick[0]) ||
                         (actSrc == 2'b01 && srcTick[1]) ||
                         (actSrc == 2'b10 && srcTick[2]))));

  assert_change_after_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (actSrc != $past(actSrc)) |-> $past(gapQ));

  assert_fail_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (guardEn && extFail) |=> (failFlag && nmi));

  assert_no_spurious_fail_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!failFlag && !(guardEn && extFail)) |=> !failFlag);

  assert_fallback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (guardEn && extFail && !gapQ && actSrc == 2'b01) |=> !clkEn ##1 (actSrc == 2'b00));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !failClr) |=> failFlag);
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
  .clk(clk), .rstN(rstN), .actSrc(actSrc), .clkEn(clkEn), .srcTick(srcTick),
  .guardEn(guardEn), .extFail(extFail), .failClr(failClr),
  .failFlag(failFlag), .nmi(nmi), .gapQ(swGap)
);

// File: tb/sim_sysclk_switch.sv
`timescale 1ns/1ps
module sim_sysclk_switch;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] reqSrc;
  logic [2:0] srcRdy, srcTick;
  logic       guardEn, pllFromExt, extFail, failClr;
  logic [1:0] actSrc;
  logic       clkEn, extOff, failFlag, nmi;

  int nChk = 0, nFail = 0;
  int mAct = 0, mGap = 0, mPend = 0, mFail = 0, mBlock = 0;
  string curTag = "R1";
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysclk_switch u0 (.*);

  function automatic int extDep(int s);
    return (s == 1 || (s == 2 && pllFromExt)) ? 1 : 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference update at a rising edge
  task automatic modelEdge();
    int fe, fc, rq, tg, nf, nb;
    if (!rstN) begin
      mAct = 0; mGap = 0; mPend = 0; mFail = 0; mBlock = 0;
      return;
    end
    fe = (guardEn && extFail) ? 1 : 0;
    fc = fe | mBlock;
    rq = (reqSrc == 3) ? 0 : int'(reqSrc);
    tg = (fc && extDep(rq)) ? 0 : rq;
    nf = fe ? 1 : (failClr ? 0 : mFail);
    nb = fe ? 1 : ((!mFail && srcRdy[1]) ? 0 : mBlock);
    if (mGap) begin
      mAct = (fe && extDep(mPend)) ? 0 : mPend;
      mGap = 0;
    end else if (fc && extDep(mAct)) begin
      mPend = 0; mGap = 1;
    end else if (tg != mAct && srcRdy[tg]) begin
      mPend = tg; mGap = 1;
    end
    mFail = nf; mBlock = nb;
  endtask

  // one cycle: inputs already set just after a falling edge
  task automatic step(bit rnd = 1);
    if (rnd) srcTick = 3'($urandom);
    #5;
    cmp(curTag, "actSrc", actSrc, mAct);
    cmp(curTag, "clkEn", clkEn, (!mGap && srcTick[mAct]) ? 1 : 0);
    cmp(curTag, "failFlag", failFlag, mFail);
    cmp(curTag, "nmi", nmi, mFail);
    cmp(curTag, "extOff", extOff, mFail);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; reqSrc = 0; srcRdy = 3'b001; srcTick = 0;
    guardEn = 0; pllFromExt = 0; extFail = 0; failClr = 0;
    @(negedge clk);
    repeat (3) step();
    rstN = 1;
    srcTick = 3'b001; #1;
    cmp("R1", "reset actSrc", actSrc, 0);
    cmp("R1", "reset clkEn", clkEn, 1);
    cmp("R1", "reset failFlag", failFlag, 0);
    step(0);

    // R2: code 11 stays on RC
    curTag = "R2"; reqSrc = 2'b11; srcRdy = 3'b111;
    repeat (4) step();
    #1 cmp("R2", "code 11 actSrc", actSrc, 0);

    // R3: pending request waits for ready
    curTag = "R3"; reqSrc = 2'b01; srcRdy = 3'b101;
    repeat (5) step();
    #1 cmp("R3", "pending actSrc", actSrc, 0);
    srcRdy = 3'b111;
    step();
    srcTick = 3'b111; #1;
    cmp("R4", "gap clkEn", clkEn, 0);
    cmp("R4", "gap actSrc", actSrc, 0);
    step(0);
    srcTick = 3'b010; #1;
    cmp("R3", "switched actSrc", actSrc, 1);
    cmp("R4", "new stream clkEn", clkEn, 1);
    step(0);

    // PLL fed from crystal
    curTag = "R10"; reqSrc = 2'b10; pllFromExt = 1;
    repeat (3) step();
    #1 cmp("R10", "pll actSrc", actSrc, 2);

    // R6: failure ignored without supervision
    curTag = "R6"; guardEn = 0; extFail = 1;
    step();
    extFail = 0; #1;
    cmp("R6", "unsupervised failFlag", failFlag, 0);
    cmp("R6", "unsupervised actSrc", actSrc, 2);
    step();

    // R7: forced fallback even with RC not ready
    curTag = "R7"; guardEn = 1; srcRdy = 3'b110; extFail = 1;
    step();
    extFail = 0; srcTick = 3'b111; #1;
    cmp("R6", "failFlag set", failFlag, 1);
    cmp("R6", "nmi set", nmi, 1);
    cmp("R7", "fallback gap clkEn", clkEn, 0);
    step(0);
    #1 cmp("R7", "fallback actSrc", actSrc, 0);

    // R9: lockout, R8: sticky flag
    curTag = "R9"; srcRdy = 3'b111;
    repeat (5) step();
    #1;
    cmp("R9", "locked actSrc", actSrc, 0);
    cmp("R8", "sticky failFlag", failFlag, 1);
    failClr = 1; extFail = 1;
    step();
    extFail = 0; #1;
    cmp("R8", "set wins over clear", failFlag, 1);
    srcRdy = 3'b101;
    step();
    failClr = 0; #1;
    cmp("R8", "cleared failFlag", failFlag, 0);
    repeat (4) step();
    #1 cmp("R9", "still locked actSrc", actSrc, 0);
    srcRdy = 3'b111;
    repeat (4) step();
    #1 cmp("R9", "unlocked actSrc", actSrc, 2);

    // R10: PLL on RC input is not moved by a failure
    curTag = "R10"; pllFromExt = 0; extFail = 1;
    step();
    extFail = 0;
    repeat (3) step();
    #1;
    cmp("R10", "pll on rc actSrc", actSrc, 2);
    cmp("R10", "pll on rc failFlag", failFlag, 1);
    failClr = 1; step(); failClr = 0;

    // random phase: handoff ordering against the model
    curTag = "R5";
    for (int i = 0; i < 3000; i++) begin
      reqSrc  = 2'($urandom);
      srcRdy  = 3'($urandom);
      guardEn = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) pllFromExt = ~pllFromExt;
      extFail = ($urandom % 40) == 0;
      failClr = ($urandom % 20) == 0;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule